// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler

This block stops a system that has lost control of its software. A free-running prescaler counts the oscillator clock. A carry taken from one of two prescaler stages advances a small watchdog counter. When that counter wraps, the block issues a one-cycle reset request and sets a sticky status flag. Software proves that it is alive by writing to one fixed service address before the counter wraps. A write of any value to that address clears the watchdog counter and the upper prescaler stages. The lowest prescaler stages keep running. So a serviced timeout can be up to sixteen cycles shorter than a full power of two.

The rate choice and the disable choice are taken from configuration while the internal reset input is high. They are then held until the next internal reset. A reset-vector-fetch strobe clears the watchdog counter, and the internal reset clears both counters. The bus side is a write-only valid/ready channel that carries only an address. The data value does not matter, so no data lines are present. The channel never applies back-pressure: ready is always high, and each cycle with valid high counts as one accepted write.

Top module: `wdog_top`

## Requirements
- R1: While rst_n is low, and after it rises, wd_reset and wd_flag are 0. wr_ready is 1 in every cycle.
- R2: The timeout period is set by the rate bit sampled during sys_rst.
  - With the rate bit at 1, the watchdog counter advances once every 2^FAST_TAP cycles. With it at 0, it advances once every 2^PRE_W cycles.
  - The counter wraps after 2^WD_W advances.
  - With no service, wd_reset goes high in the cycle after the 2^(TAP+WD_W)-th rising edge that follows the release of sys_rst. With default parameters at the slow rate this is 2^18 cycles, about 21.8 ms at 12 MHz.
- R3: wd_reset is high for exactly one cycle per wrap.
- R4: An accepted write with wr_addr equal to SVC_ADDR (all ones, 0xFFFF by default) services the watchdog.
  - It clears the watchdog counter and the prescaler bits above the low KEEP_W bits.
  - The low bits keep counting.
  - The next wd_reset follows 2^N − L edges after the service edge, where L is the low-field value after that edge. The residual is therefore between 2^N − 16 and 2^N.
- R5: A write to any other address has no effect on the time at which wd_reset appears.
- R6: vec_fetch clears the watchdog counter only. The prescaler phase is kept, so the next wrap comes 2^WD_W advances after the next prescaler carry.
- R7: sys_rst high clears both counters, holds wd_reset low and loads the rate and disable bits. Changes on cfg_fast or cfg_off while sys_rst is low are ignored.
- R8: With the latched disable bit at 1, wd_reset never rises and wd_flag stays 0.
- R9: wd_flag is set in the same cycle as wd_reset and stays set through sys_rst. flag_clr clears it one edge later, unless a new wrap occurs at that edge. rst_n also clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst | input | 1 | Internal reset from the system reset logic, active high, synchronous |
| cfg_fast | input | 1 | Rate select: 1 = short timeout, 0 = long timeout |
| cfg_off | input | 1 | 1 = watchdog may not raise a reset |
| vec_fetch | input | 1 | Reset-vector fetch strobe |
| wr_valid | input | 1 | Bus write request |
| wr_ready | output | 1 | Always 1; the channel never stalls |
| wr_addr | input | ADDR_W | Bus write address |
| flag_clr | input | 1 | Status read-and-clear strobe |
| wd_reset | output | 1 | One-cycle watchdog reset request |
| wd_flag | output | 1 | Sticky watchdog-reset status |

## Verification
The hardest case to reach is a service write that lands while the low prescaler stages hold a nonzero value. This is the case that shortens the residual timeout, and the shortfall is invisible unless the write edge is chosen on purpose. The stimulus counts edges from the release of sys_rst and places the service write on an edge whose value mod 16 is nonzero (1003 and 20007). It then measures the exact edge of the next wd_reset. A vector fetch placed between two prescaler carries shows that the prescaler phase is kept.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Settings captured while the system is held in reset
  typedef struct packed {
    logic fast;   // 1: short timeout tap
    logic off;    // 1: reset request suppressed
  } wdog_cfg_t;

endpackage

// File: rtl/wdog_cfg_latch.sv
module wdog_cfg_latch
  import wdog_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  wdog_cfg_t cfg_in,
  output wdog_cfg_t cfg_q
);

  // Configuration follows its inputs only while load (internal reset) is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (load) cfg_q <= cfg_in;
  end

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRE_W    = 12,
  parameter int FAST_TAP = 7,
  parameter int KEEP_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             clr_upper,
  input  logic             fast,
  output logic             tick,
  output logic [PRE_W-1:0] count
);

  localparam int UP_W = PRE_W - KEEP_W;

  logic [KEEP_W-1:0] low_q;
  logic [UP_W-1:0]   up_q;
  logic              low_carry;
  logic              carry_fast;
  logic              carry_slow;

  assign low_carry = &low_q;

  // Low stages are never touched by a service write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       low_q <= '0;
    else if (clr_all) low_q <= '0;
    else              low_q <= low_q + 1'b1;
  end

  // Upper stages: cleared by service, advanced by the low-stage carry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      up_q <= '0;
    else if (clr_all || clr_upper)   up_q <= '0;
    else if (low_carry)              up_q <= up_q + 1'b1;
  end

  assign count = {up_q, low_q};

  // Carry out of the selected stage: all stages below and at the tap are ones
  generate
    if (FAST_TAP <= KEEP_W) begin : g_tap_low
      assign carry_fast = &low_q[FAST_TAP-1:0];
    end else begin : g_tap_up
      assign carry_fast = low_carry & (&up_q[FAST_TAP-KEEP_W-1:0]);
    end
  endgenerate

  assign carry_slow = low_carry & (&up_q);
  assign tick       = fast ? carry_fast : carry_slow;

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int WD_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            tick,
  output logic            wrap,
  output logic [WD_W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  // Carry out of the top stage; a clear in the same cycle wins
  assign wrap = tick & (&cnt) & ~clr;

endmodule

// File: rtl/wdog_status.sv
module wdog_status (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic off,
  input  logic hold,
  input  logic flag_clr,
  output logic pulse,
  output logic flag
);

  logic fire;

  assign fire = wrap & ~off & ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      flag  <= 1'b0;
    end else begin
      pulse <= fire;
      flag  <= fire | (flag & ~flag_clr);
    end
  end

endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int PRE_W    = 12,
  parameter int FAST_TAP = 7,
  parameter int KEEP_W   = 4,
  parameter int WD_W     = 6,
  parameter int ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_rst,
  input  logic              cfg_fast,
  input  logic              cfg_off,
  input  logic              vec_fetch,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              flag_clr,
  output logic              wd_reset,
  output logic              wd_flag
);

  wdog_cfg_t        cfg_in;
  wdog_cfg_t        cfg_q;
  logic             svc_hit;
  logic             cnt_clr;
  logic             tick;
  logic             wrap;
  logic [PRE_W-1:0] pre_cnt;
  logic [WD_W-1:0]  wd_cnt;

  assign wr_ready = 1'b1;
  assign svc_hit  = wr_valid & wr_ready & (wr_addr == SVC_ADDR);
  assign cnt_clr  = sys_rst | svc_hit | vec_fetch;

  assign cfg_in.fast = cfg_fast;
  assign cfg_in.off  = cfg_off;

  wdog_cfg_latch u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (sys_rst),
    .cfg_in (cfg_in),
    .cfg_q  (cfg_q)
  );

  wdog_prescaler #(
    .PRE_W    (PRE_W),
    .FAST_TAP (FAST_TAP),
    .KEEP_W   (KEEP_W)
  ) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all   (sys_rst),
    .clr_upper (svc_hit),
    .fast      (cfg_q.fast),
    .tick      (tick),
    .count     (pre_cnt)
  );

  wdog_counter #(
    .WD_W (WD_W)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .tick  (tick),
    .wrap  (wrap),
    .cnt   (wd_cnt)
  );

  wdog_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrap     (wrap),
    .off      (cfg_q.off),
    .hold     (sys_rst),
    .flag_clr (flag_clr),
    .pulse    (wd_reset),
    .flag     (wd_flag)
  );

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int PRE_W  = 12,
  parameter int KEEP_W = 4,
  parameter int WD_W   = 6,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sys_rst,
  input logic              vec_fetch,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              flag_clr,
  input logic              wd_reset,
  input logic              wd_flag,
  input logic [1:0]        cfg_bits,
  input logic [PRE_W-1:0]  pre_cnt,
  input logic [WD_W-1:0]   wd_cnt
);

  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset |=> !wd_reset);

  assert_flag_with_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset |-> wd_flag);

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> (wd_flag == wd_reset));

  assert_off_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bits[0] |-> !wd_reset);

  assert_hold_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> (wd_cnt == '0 && pre_cnt == '0 && !wd_reset));

  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst |=> $stable(cfg_bits));

  assert_service_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == SVC_ADDR && !sys_rst) |=>
      (wd_cnt == '0 && pre_cnt[PRE_W-1:KEEP_W] == '0));

  assert_vec_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch |=> wd_cnt == '0);

endmodule

bind wdog_top wdog_checker #(
  .PRE_W    (PRE_W),
  .KEEP_W   (KEEP_W),
  .WD_W     (WD_W),
  .ADDR_W   (ADDR_W),
  .SVC_ADDR (SVC_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sys_rst   (sys_rst),
  .vec_fetch (vec_fetch),
  .wr_valid  (wr_valid),
  .wr_addr   (wr_addr),
  .flag_clr  (flag_clr),
  .wd_reset  (wd_reset),
  .wd_flag   (wd_flag),
  .cfg_bits  (cfg_q),
  .pre_cnt   (pre_cnt),
  .wd_cnt    (wd_cnt)
);

// File: tb/wdog_top_test.sv
`timescale 1ns/1ps
module wdog_top_test;

  localparam int PRE  = 9;
  localparam int FAST = 5;
  localparam int KEEP = 4;
  localparam int WDW  = 6;
  localparam int AW   = 16;
  localparam logic [AW-1:0] SVC = 16'hFFFF;
  localparam int T_SLOW = 1 << (PRE + WDW);
  localparam int T_FAST = 1 << (FAST + WDW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_rst = 1'b0;
  logic cfg_fast = 1'b0;
  logic cfg_off = 1'b0;
  logic vec_fetch = 1'b0;
  logic wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic flag_clr = 1'b0;
  logic wr_ready, wd_reset, wd_flag;

  int n_run = 0;
  int n_fail = 0;
  int edge_n = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_top #(.PRE_W(PRE), .FAST_TAP(FAST), .KEEP_W(KEEP), .WD_W(WDW),
             .ADDR_W(AW), .SVC_ADDR(SVC)) uut (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .cfg_fast(cfg_fast),
    .cfg_off(cfg_off), .vec_fetch(vec_fetch), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .flag_clr(flag_clr),
    .wd_reset(wd_reset), .wd_flag(wd_flag));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // edges since internal reset release
  always @(posedge clk) begin
    if (sys_rst) edge_n <= 0;
    else         edge_n <= edge_n + 1;
  end

  // behavioural reference: integer phase and integer wrap count
  int m_pre, m_wd, m_mod;
  bit m_fast, m_off, m_pulse, m_flag, m_fire, m_svc, m_tick;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_wd = 0; m_fast = 0; m_off = 0; m_pulse = 0; m_flag = 0;
    end else begin
      m_fire = 0;
      m_svc  = wr_valid && (wr_addr == SVC);
      m_mod  = m_fast ? (1 << FAST) : (1 << PRE);
      m_tick = ((m_pre + 1) % m_mod) == 0;
      if (sys_rst) begin
        m_pre = 0; m_wd = 0; m_fast = cfg_fast; m_off = cfg_off;
      end else begin
        m_pre = m_svc ? (m_pre + 1) % (1 << KEEP) : (m_pre + 1) % (1 << PRE);
        if (m_svc || vec_fetch) m_wd = 0;
        else if (m_tick) begin
          if (m_wd == (1 << WDW) - 1) begin m_wd = 0; m_fire = !m_off; end
          else m_wd++;
        end
      end
      m_pulse = m_fire;
      m_flag  = m_fire | (m_flag & !flag_clr);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(wd_reset == m_pulse, "R3", "wd_reset vs model", wd_reset, m_pulse);
      chk(wd_flag == m_flag, "R9", "wd_flag vs model", wd_flag, m_flag);
      chk(wr_ready == 1'b1, "R1", "wr_ready", wr_ready, 1);
    end
  end

  task automatic release_with(input bit fast, input bit off);
    @(negedge clk);
    sys_rst = 1'b1; cfg_fast = fast; cfg_off = off;
    repeat (2) @(negedge clk);
    sys_rst = 1'b0;
  endtask

  task automatic run_to(input int n);
    while (edge_n < n) @(negedge clk);
  endtask

  task automatic wait_pulse(input int limit, output int at);
    at = -1;
    while (edge_n < limit) begin
      @(negedge clk);
      if (wd_reset) begin at = edge_n; break; end
    end
  endtask

  task automatic write_at(input int e, input logic [AW-1:0] a);
    run_to(e - 1);
    wr_valid = 1'b1; wr_addr = a;
    @(negedge clk);
    wr_valid = 1'b0; wr_addr = '0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin : main
    int at;
    int res;
    repeat (3) @(negedge clk);
    chk(wd_reset == 1'b0, "R1", "reset wd_reset", wd_reset, 0);
    chk(wd_flag == 1'b0, "R1", "reset wd_flag", wd_flag, 0);
    rst_n = 1'b1;

    // R2 slow rate, full period
    release_with(1'b0, 1'b0);
    wait_pulse(T_SLOW + 10, at);
    chk(at == T_SLOW, "R2", "slow timeout edge", at, T_SLOW);
    @(negedge clk);
    chk(wd_reset == 1'b0, "R3", "pulse width", wd_reset, 0);
    chk(wd_flag == 1'b1, "R9", "flag sticky", wd_flag, 1);
    release_with(1'b1, 1'b0);
    chk(wd_flag == 1'b1, "R9", "flag across sys_rst", wd_flag, 1);
    clear_flag();
    chk(wd_flag == 1'b0, "R9", "flag cleared", wd_flag, 0);

    // R2 fast rate
    release_with(1'b1, 1'b0);
    wait_pulse(T_FAST + 10, at);
    chk(at == T_FAST, "R2", "fast timeout edge", at, T_FAST);
    clear_flag();

    // R4 service mid-count, low field 11
    release_with(1'b1, 1'b0);
    write_at(1003, SVC);
    wait_pulse(1003 + T_FAST + 10, at);
    res = at - 1003;
    chk(at == 1003 + T_FAST - 11, "R4", "serviced fast edge", at, 1003 + T_FAST - 11);
    chk(res >= T_FAST - 16 && res <= T_FAST, "R4", "residual range", res, T_FAST);
    clear_flag();

    // R4 slow rate, low field 7
    release_with(1'b0, 1'b0);
    write_at(20007, SVC);
    wait_pulse(20007 + T_SLOW + 10, at);
    chk(at == 20007 + T_SLOW - 7, "R4", "serviced slow edge", at, 20007 + T_SLOW - 7);
    clear_flag();

    // R5 other address ignored
    release_with(1'b1, 1'b0);
    write_at(1003, 16'hFFFE);
    wait_pulse(T_FAST + 10, at);
    chk(at == T_FAST, "R5", "foreign write timing", at, T_FAST);
    clear_flag();

    // R6 vector fetch keeps prescaler phase
    release_with(1'b1, 1'b0);
    run_to(1002);
    vec_fetch = 1'b1;
    @(negedge clk);
    vec_fetch = 1'b0;
    wait_pulse(4000, at);
    chk(at == 1024 + 63 * 32, "R6", "vec fetch timing", at, 1024 + 63 * 32);
    clear_flag();

    // R7 config change after release ignored, sys_rst mid-count restarts
    release_with(1'b1, 1'b0);
    cfg_fast = 1'b0; cfg_off = 1'b1;
    run_to(1500);
    sys_rst = 1'b1;
    @(negedge clk);
    cfg_fast = 1'b1; cfg_off = 1'b0;
    @(negedge clk);
    sys_rst = 1'b0;
    cfg_fast = 1'b0; cfg_off = 1'b1;
    wait_pulse(T_FAST + 10, at);
    chk(at == T_FAST, "R7", "late config ignored", at, T_FAST);
    clear_flag();

    // R8 disabled never resets
    release_with(1'b1, 1'b1);
    cfg_off = 1'b0;
    wait_pulse(3 * T_FAST + 10, at);
    chk(at == -1, "R8", "disabled pulse edge", at, -1);
    chk(wd_flag == 1'b0, "R8", "disabled flag", wd_flag, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule